// File: doc/BRIEF.md
# Carry-Pipelined Phase Accumulator Synthesizer

This block is a direct digital synthesis core. It produces a single-bit stream: the overflow of a wide phase accumulator that adds a tuning word on every enabled clock. The average rate of that bit is the tuning word divided by two to the accumulator width, times the clock rate. A 32-bit accumulator sets the frequency in steps of about a quarter of a part per billion. The block produces no sine lookup and no converter interface. The carry stream is the product.

To run at a high clock rate, the wide adder is cut into equal segments, with a register in the carry path between neighbours. Segment k therefore runs k clock cycles behind the lowest segment. The slice of the tuning word that feeds segment k passes through k matching delay stages, so a newly loaded word reaches every segment on the same accumulator step. The top carry is an exact copy of the overflow of an unpipelined accumulator, delayed by one cycle per inner carry register. The raw, skewed segment values are also brought out so that the alignment can be observed.

Top module: `carry_dds`

## Requirements
- R1: While `rst` is high at a clock edge, all segment registers, carry registers, delay stages and the tuning register clear to zero, so `phaseOut` is 0 and `carryOut` is 0 after that edge.
- R2: On each enabled edge, the lowest segment (`phaseOut[SEG_W-1:0]`) becomes its old value plus the low SEG_W bits of the active tuning word, modulo 2^SEG_W.
- R3: `carryOut` after enabled step s equals the overflow that an unpipelined ACC_W-bit accumulator produced on its step s-(NUM_SEG-1), and is 0 when that index is not positive.
- R4: Field `phaseOut[k*SEG_W +: SEG_W]` holds bits k*SEG_W to (k+1)*SEG_W-1 of the unpipelined accumulator as it stood k enabled steps earlier, and is 0 before that many steps have passed since reset.
- R5: `ftwIn` is captured whenever `load` is high at an edge, whether or not `en` is high. The captured word is added from the next enabled step on, and every segment switches to it on the same accumulator step.
- R6: With `en` low, `phaseOut`, `carryOut` and the delay stages hold their values. When `en` rises again, the sequence resumes as if the idle cycles never happened.
- R7: With a tuning word of zero, `carryOut` stays 0 and `phaseOut` stays constant.
- R8: With a tuning word of one, `carryOut` stays 0 until the accumulator wraps.
- R9: With an all-ones tuning word starting from zero, the first step gives no overflow and every later step overflows. `carryOut` shows this pattern after the latency of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the accumulator pipeline this cycle |
| load | input | 1 | Capture `ftwIn` as the tuning word |
| ftwIn | input | ACC_W | Frequency tuning word |
| carryOut | output | 1 | Delayed overflow of the accumulator (synthesized output) |
| phaseOut | output | ACC_W | Raw segment registers, segment k in bits k*SEG_W and up |

## Verification
The carry stream and every segment field are compared each cycle against a bench accumulator with one full-width adder. That comparison is done under five kinds of input:

- A zero word exposes any spurious carry.
- A word of one checks that carries never leave the low segment early.
- An all-ones word forces a carry through every segment register on every step, which exposes any skew mismatch.
- A mixed-bit word changed mid-run shows whether all segments switch to the new word on the same step.
- Runs with `en` held low, including a load while held, tell a pipeline that freezes as a whole apart from one that lets the segments drift out of alignment.

// File: rtl/carry_dds_pkg.sv
package carry_dds_pkg;

  typedef struct packed {
    logic step;  // advance every segment, carry and delay stage
    logic take;  // capture a new tuning word
  } ctrl_t;

endpackage

// File: rtl/carry_dds_ctrl.sv
module carry_dds_ctrl
  import carry_dds_pkg::*;
(
  input  logic  rst,
  input  logic  en,
  input  logic  load,
  output ctrl_t ctrl
);

  // Reset overrides both strobes; enable and load are otherwise independent.
  always_comb begin
    ctrl.step = en & ~rst;
    ctrl.take = load & ~rst;
  end

endmodule

// File: rtl/carry_dds_path.sv
module carry_dds_path
  import carry_dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int NUM_SEG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl,
  input  logic [ACC_W-1:0] ftwIn,
  output logic [ACC_W-1:0] ftwCur,
  output logic [ACC_W-1:0] phaseOut,
  output logic             carryOut
);

  localparam int SEG_W = ACC_W / NUM_SEG;

  logic [NUM_SEG-1:0] cyVec;

  // Active tuning word.
  always_ff @(posedge clk) begin
    if (rst)            ftwCur <= '0;
    else if (ctrl.take) ftwCur <= ftwIn;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic [SEG_W-1:0] addend;
    logic             cyIn;
    logic [SEG_W-1:0] segQ;
    logic             cyQ;
    logic [SEG_W:0]   sum;

    if (k == 0) begin : g_base
      assign addend = ftwCur[SEG_W-1:0];
      assign cyIn   = 1'b0;
    end else begin : g_lag
      // Tuning slice delayed by the same depth as this segment's carry skew.
      logic [SEG_W-1:0] lagQ [k];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < k; j++) lagQ[j] <= '0;
        end else if (ctrl.step) begin
          lagQ[0] <= ftwCur[k*SEG_W +: SEG_W];
          for (int j = 1; j < k; j++) lagQ[j] <= lagQ[j-1];
        end
      end
      assign addend = lagQ[k-1];
      assign cyIn   = cyVec[k-1];
    end

    assign sum = {1'b0, segQ} + {1'b0, addend} + {{SEG_W{1'b0}}, cyIn};

    always_ff @(posedge clk) begin
      if (rst) begin
        segQ <= '0;
        cyQ  <= 1'b0;
      end else if (ctrl.step) begin
        segQ <= sum[SEG_W-1:0];
        cyQ  <= sum[SEG_W];
      end
    end

    assign phaseOut[k*SEG_W +: SEG_W] = segQ;
    assign cyVec[k] = cyQ;
  end

  assign carryOut = cyVec[NUM_SEG-1];

endmodule

// File: rtl/carry_dds.sv
module carry_dds
  import carry_dds_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int NUM_SEG = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [ACC_W-1:0] ftwIn,
  output logic             carryOut,
  output logic [ACC_W-1:0] phaseOut
);

  ctrl_t            ctrl;
  logic [ACC_W-1:0] ftwCur;

  carry_dds_ctrl u_ctrl (
    .rst  (rst),
    .en   (en),
    .load (load),
    .ctrl (ctrl)
  );

  carry_dds_path #(
    .ACC_W   (ACC_W),
    .NUM_SEG (NUM_SEG)
  ) u_path (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .ftwIn    (ftwIn),
    .ftwCur   (ftwCur),
    .phaseOut (phaseOut),
    .carryOut (carryOut)
  );

endmodule

// File: rtl/carry_dds_chk.sv
module carry_dds_chk #(
  parameter int ACC_W   = 32,
  parameter int NUM_SEG = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [ACC_W-1:0] ftwCur,
  input logic [ACC_W-1:0] phaseOut,
  input logic             carryOut
);

  localparam int SEG_W = ACC_W / NUM_SEG;

  logic [SEG_W-1:0] lowNext;
  assign lowNext = phaseOut[SEG_W-1:0] + ftwCur[SEG_W-1:0];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (phaseOut == '0) && !carryOut);

  // R2
  low_seg_add_chk: assert property (@(posedge clk) disable iff (rst)
    en |=> phaseOut[SEG_W-1:0] == $past(lowNext));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phaseOut) && $stable(carryOut));

  // R6
  carry_rise_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(carryOut) |-> $past(en));

endmodule

bind carry_dds carry_dds_chk #(
  .ACC_W   (ACC_W),
  .NUM_SEG (NUM_SEG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .ftwCur   (ftwCur),
  .phaseOut (phaseOut),
  .carryOut (carryOut)
);

// File: tb/carry_dds_tb.sv
module carry_dds_tb;

  localparam int ACC_W   = 32;
  localparam int NUM_SEG = 4;
  localparam int SEG_W   = ACC_W / NUM_SEG;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic             load = 1'b0;
  logic [ACC_W-1:0] ftwIn = '0;
  logic             carryOut;
  logic [ACC_W-1:0] phaseOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cycles = 0;

  // Bench reference: one full-width accumulator plus history of its steps.
  logic [ACC_W-1:0] refAcc;
  logic [ACC_W-1:0] refFtw;
  logic [ACC_W-1:0] accH [NUM_SEG];
  logic             cyH  [NUM_SEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_dds #(.ACC_W(ACC_W), .NUM_SEG(NUM_SEG)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .load     (load),
    .ftwIn    (ftwIn),
    .carryOut (carryOut),
    .phaseOut (phaseOut)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkOut(input string tag);
    logic [SEG_W-1:0] expSeg;
    total = total + 1;
    if (carryOut !== cyH[NUM_SEG-1]) begin
      bad = bad + 1;
      $display("FAIL %s carry: actual=%0b expected=%0b", tag, carryOut, cyH[NUM_SEG-1]);
    end
    for (int k = 0; k < NUM_SEG; k++) begin
      expSeg = accH[k][k*SEG_W +: SEG_W];
      total = total + 1;
      if (phaseOut[k*SEG_W +: SEG_W] !== expSeg) begin
        bad = bad + 1;
        $display("FAIL %s segment %0d: actual=%h expected=%h", tag, k,
                 phaseOut[k*SEG_W +: SEG_W], expSeg);
      end
    end
  endtask

  // One clock: drive inputs, advance the model on the same edge, compare.
  task automatic tick(input logic r, input logic e, input logic l,
                      input logic [ACC_W-1:0] w, input string tag);
    logic [ACC_W:0] s;
    rst = r; en = e; load = l; ftwIn = w;
    @(posedge clk);
    #1;
    if (r) begin
      refAcc = '0;
      refFtw = '0;
      for (int i = 0; i < NUM_SEG; i++) begin
        accH[i] = '0;
        cyH[i]  = 1'b0;
      end
    end else begin
      if (e) begin
        s = {1'b0, refAcc} + {1'b0, refFtw};
        for (int i = NUM_SEG-1; i > 0; i--) begin
          accH[i] = accH[i-1];
          cyH[i]  = cyH[i-1];
        end
        accH[0] = s[ACC_W-1:0];
        cyH[0]  = s[ACC_W];
        refAcc  = s[ACC_W-1:0];
      end
      if (l) refFtw = w;
    end
    checkOut(tag);
  endtask

  task automatic tReset();
    tick(1'b1, 1'b1, 1'b1, 32'hDEADBEEF, "R1");
    tick(1'b1, 1'b0, 1'b0, '0, "R1");
    total = total + 1;
    if (phaseOut !== '0 || carryOut !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R1 reset: actual=%h/%0b expected=0/0", phaseOut, carryOut);
    end
  endtask

  task automatic tRun(input logic [ACC_W-1:0] w, input int n, input string tag);
    tick(1'b0, 1'b0, 1'b1, w, tag);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1, 1'b0, '0, tag);
  endtask

  task automatic tZero();
    logic [ACC_W-1:0] start;
    tReset();
    tRun('0, 20, "R7");
    start = phaseOut;
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1, 1'b0, '0, "R7");
    total = total + 1;
    if (phaseOut !== start || carryOut !== 1'b0) begin
      bad = bad + 1;
      $display("FAIL R7 zero word: actual=%h/%0b expected=%h/0", phaseOut, carryOut, start);
    end
  endtask

  task automatic tOne();
    tReset();
    tRun(32'h0000_0001, 600, "R8");
  endtask

  task automatic tOnes();
    tReset();
    tRun('1, 40, "R9");
  endtask

  task automatic tSwitch();
    tReset();
    tRun(32'h1357_9BDF, 300, "R3");
    // Load mid-run while enabled: all segments move to the new word together.
    tick(1'b0, 1'b1, 1'b1, 32'hF0E1_D2C3, "R5");
    for (int i = 0; i < 300; i++) tick(1'b0, 1'b1, 1'b0, '0, "R4");
    tick(1'b0, 1'b1, 1'b1, 32'h8000_0001, "R5");
    for (int i = 0; i < 100; i++) tick(1'b0, 1'b1, 1'b0, '0, "R2");
  endtask

  task automatic tFreeze();
    logic [ACC_W-1:0] held;
    logic             heldCy;
    tReset();
    tRun(32'hC0FF_EE11, 50, "R6");
    held = phaseOut;
    heldCy = carryOut;
    for (int i = 0; i < 7; i++) tick(1'b0, 1'b0, 1'b0, '0, "R6");
    total = total + 1;
    if (phaseOut !== held || carryOut !== heldCy) begin
      bad = bad + 1;
      $display("FAIL R6 freeze: actual=%h/%0b expected=%h/%0b", phaseOut, carryOut, held, heldCy);
    end
    // Load while frozen is captured, then used once enabled.
    tick(1'b0, 1'b0, 1'b1, 32'h7FFF_FFFF, "R5");
    total = total + 1;
    if (phaseOut !== held) begin
      bad = bad + 1;
      $display("FAIL R5 frozen load moved phase: actual=%h expected=%h", phaseOut, held);
    end
    for (int i = 0; i < 200; i++) begin
      tick(1'b0, 1'b1, 1'b0, '0, "R5");
      if (i % 9 == 4) tick(1'b0, 1'b0, 1'b0, '0, "R6");
    end
  endtask

  initial begin
    for (int i = 0; i < NUM_SEG; i++) begin
      accH[i] = '0;
      cyH[i]  = 1'b0;
    end
    refAcc = '0;
    refFtw = '0;
    tReset();
    tZero();
    tOne();
    tOnes();
    tSwitch();
    tFreeze();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule